// File: doc/BRIEF.md
# Free-Running Match Timer

This block is a counter with three match comparators, set up and read over a simple synchronous register bus. A 32-bit up-counter advances on ticks from one of several prescaled tick-enable inputs. Which input it uses is chosen by a select field. In free-running mode the counter wraps past its maximum. In periodic mode a match on comparator 0 reloads the counter from a restart register.

Each comparator watches for the count reaching its match value and then sets a sticky status bit. Software clears a status bit by writing 1 to the acknowledge register. A per-comparator enable decides whether a status bit drives the shared interrupt line. Because the counter may run from a different timing source than the reader, software reads the count by writing 1 to the snapshot register, waiting, and then reading the captured value back from the same address.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads 0, the counter is stopped at 0 and `irq` is low.
- R2: Bit 0 of RUN (word address 0) starts the counter. While that bit is 0 the count holds its value.
- R3: CLKSEL (address 1, bits [1:0]) selects which `tick_in` bit advances the counter. Ticks on any other bit have no effect on the count.
- R4: With MODE (address 2) bit 0 set to 1 (free-running), each counting tick adds 1 modulo 2^32, so 0xFFFFFFFF goes to 0. A match never reloads the counter in this mode.
- R5: With MODE bit 0 set to 0 (periodic), a counting tick taken while the count equals MATCH0 loads the count from PRELOAD (address 3). A PRELOAD of 0 restarts the counter from 0.
- R6: Writing a word with bit 0 set to 1 to SNAP (address 4) captures the count held just before that write's clock edge. The captured value reads back from SNAP once SNAP_DELAY cycles have passed. Writing a word with bit 0 set to 0 captures nothing.
- R7: STATUS (address 5) bit i sets on a counting tick at which the count equals MATCHi (addresses 8, 9 and 10 for i = 0, 1, 2). The bit stays set until it is cleared.
- R8: Writing 1 to bit i of ACK (address 6) clears STATUS bit i. Writing 0x7 clears all three bits. Bits written as 0 leave status untouched. ACK reads as 0.
- R9: When a set event and an acknowledge for the same bit fall in the same cycle, the bit ends up set.
- R10: `irq` is high exactly when some STATUS bit i is set and IRQEN (address 7) bit i is 1. Changing IRQEN disturbs neither the count nor STATUS.
- R11: Read data appears on `bus_rdata` in the cycle after the read request. Addresses 11 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_in | input | 4 | Prescaled tick-enables, one per clock source |
| irq | output | 1 | Combined masked match interrupt |

## Verification
The assertions assume that `tick_in` and the bus signals hold steady around each clock edge, and that only one bus access is made per cycle. They take the acknowledge strobe as it comes from the decoded write, and they rely on the match registers being changed only by bus writes. The stimulus drives every input on the falling edge. It writes match values as the modelled count plus a delta of at least 16, so that a compare is always pending ahead of the counter. It times the collision of a set and an acknowledge from the bench's own count model rather than by chance.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

  // Word addresses of the register map
  localparam int REG_RUN     = 0;
  localparam int REG_CLKSEL  = 1;
  localparam int REG_MODE    = 2;
  localparam int REG_PRELOAD = 3;
  localparam int REG_SNAP    = 4;
  localparam int REG_STATUS  = 5;
  localparam int REG_ACK     = 6;
  localparam int REG_IRQEN   = 7;
  localparam int REG_MATCH0  = 8;

  typedef enum logic {
    MODE_PERIODIC = 1'b0,
    MODE_FREE     = 1'b1
  } cnt_mode_e;

endpackage

// File: rtl/mtmr_regs.sv
module mtmr_regs
  import mtmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int N_CMP  = 3,
  parameter int SEL_W  = 2,
  parameter int ADDR_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_sel,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [CNT_W-1:0]            bus_wdata,
  input  logic [CNT_W-1:0]            snap_value,
  input  logic [N_CMP-1:0]            status,
  output logic                        run,
  output logic [SEL_W-1:0]            clksel,
  output cnt_mode_e                   mode,
  output logic [CNT_W-1:0]            preload,
  output logic [N_CMP-1:0]            ien,
  output logic [N_CMP-1:0][CNT_W-1:0] match,
  output logic                        snap_req,
  output logic [N_CMP-1:0]            ack_bits,
  output logic [CNT_W-1:0]            bus_rdata
);

  logic wr_en, rd_en;
  logic [CNT_W-1:0] rd_mux;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  function automatic logic addr_is(input logic [ADDR_W-1:0] a, input int r);
    return int'(a) == r;
  endfunction

  assign snap_req = wr_en && addr_is(bus_addr, REG_SNAP) && bus_wdata[0];
  assign ack_bits = (wr_en && addr_is(bus_addr, REG_ACK)) ? bus_wdata[N_CMP-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      clksel  <= '0;
      mode    <= MODE_PERIODIC;
      preload <= '0;
      ien     <= '0;
    end else if (wr_en) begin
      if (addr_is(bus_addr, REG_RUN))     run     <= bus_wdata[0];
      if (addr_is(bus_addr, REG_CLKSEL))  clksel  <= bus_wdata[SEL_W-1:0];
      if (addr_is(bus_addr, REG_MODE))    mode    <= cnt_mode_e'(bus_wdata[0]);
      if (addr_is(bus_addr, REG_PRELOAD)) preload <= bus_wdata;
      if (addr_is(bus_addr, REG_IRQEN))   ien     <= bus_wdata[N_CMP-1:0];
    end
  end

  for (genvar g = 0; g < N_CMP; g++) begin : g_match
    always_ff @(posedge clk) begin
      if (rst)
        match[g] <= '0;
      else if (wr_en && addr_is(bus_addr, REG_MATCH0 + g))
        match[g] <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_is(bus_addr, REG_RUN))     rd_mux = CNT_W'(run);
    if (addr_is(bus_addr, REG_CLKSEL))  rd_mux = CNT_W'(clksel);
    if (addr_is(bus_addr, REG_MODE))    rd_mux = CNT_W'(mode);
    if (addr_is(bus_addr, REG_PRELOAD)) rd_mux = preload;
    if (addr_is(bus_addr, REG_SNAP))    rd_mux = snap_value;
    if (addr_is(bus_addr, REG_STATUS))  rd_mux = CNT_W'(status);
    if (addr_is(bus_addr, REG_IRQEN))   rd_mux = CNT_W'(ien);
    for (int i = 0; i < N_CMP; i++)
      if (addr_is(bus_addr, REG_MATCH0 + i)) rd_mux = match[i];
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (rd_en)
      bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/mtmr_counter.sv
module mtmr_counter
  import mtmr_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int N_SRC      = 4,
  parameter int SEL_W      = 2,
  parameter int SNAP_DELAY = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] clksel,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] preload,
  input  logic [CNT_W-1:0] match0,
  input  logic [N_SRC-1:0] tick_in,
  input  logic             snap_req,
  output logic [CNT_W-1:0] count,
  output logic             cnt_step,
  output logic             reload,
  output logic [CNT_W-1:0] snap_value
);

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] restart,
                                                  input logic             take_restart);
    return take_restart ? restart : cur + CNT_W'(1);
  endfunction

  assign cnt_step = run && tick_in[clksel];
  assign reload   = (mode == MODE_PERIODIC) && (count == match0);

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (cnt_step)
      count <= next_count(count, preload, reload);
  end

  // Snapshot transfer: one capture stage, then SNAP_DELAY-1 carry stages
  logic [SNAP_DELAY-1:0]            pipe_v;
  logic [SNAP_DELAY-1:0][CNT_W-1:0] pipe_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_v[0] <= 1'b0;
      pipe_d[0] <= '0;
    end else begin
      pipe_v[0] <= snap_req;
      if (snap_req) pipe_d[0] <= count;
    end
  end

  for (genvar k = 1; k < SNAP_DELAY; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        pipe_v[k] <= 1'b0;
        pipe_d[k] <= '0;
      end else begin
        pipe_v[k] <= pipe_v[k-1];
        pipe_d[k] <= pipe_d[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      snap_value <= '0;
    else if (pipe_v[SNAP_DELAY-1])
      snap_value <= pipe_d[SNAP_DELAY-1];
  end

endmodule

// File: rtl/mtmr_compare.sv
module mtmr_compare #(
  parameter int CNT_W = 32,
  parameter int N_CMP = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [CNT_W-1:0]            count,
  input  logic                        cnt_step,
  input  logic [N_CMP-1:0][CNT_W-1:0] match,
  input  logic [N_CMP-1:0]            ack_bits,
  output logic [N_CMP-1:0]            match_hit,
  output logic [N_CMP-1:0]            status
);

  // Set has priority over an acknowledge in the same cycle
  function automatic logic sticky_next(input logic cur, input logic clr, input logic set);
    return set | (cur & ~clr);
  endfunction

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    assign match_hit[g] = cnt_step && (count == match[g]);

    always_ff @(posedge clk) begin
      if (rst)
        status[g] <= 1'b0;
      else
        status[g] <= sticky_next(status[g], ack_bits[g], match_hit[g]);
    end
  end

endmodule

// File: rtl/match_timer.sv
module match_timer
  import mtmr_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int N_CMP      = 3,
  parameter int N_SRC      = 4,
  parameter int ADDR_W     = 4,
  parameter int SNAP_DELAY = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [N_SRC-1:0]  tick_in,
  output logic              irq
);

  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic                        run;
  logic [SEL_W-1:0]            clksel;
  cnt_mode_e                   mode;
  logic [CNT_W-1:0]            preload;
  logic [N_CMP-1:0]            ien;
  logic [N_CMP-1:0][CNT_W-1:0] match;
  logic                        snap_req;
  logic [N_CMP-1:0]            ack_bits;
  logic [CNT_W-1:0]            count;
  logic                        cnt_step;
  logic                        reload;
  logic [CNT_W-1:0]            snap_value;
  logic [N_CMP-1:0]            match_hit;
  logic [N_CMP-1:0]            status;

  mtmr_regs #(.CNT_W(CNT_W), .N_CMP(N_CMP), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .snap_value(snap_value), .status(status), .run(run),
    .clksel(clksel), .mode(mode), .preload(preload), .ien(ien), .match(match),
    .snap_req(snap_req), .ack_bits(ack_bits), .bus_rdata(bus_rdata)
  );

  mtmr_counter #(.CNT_W(CNT_W), .N_SRC(N_SRC), .SEL_W(SEL_W), .SNAP_DELAY(SNAP_DELAY)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .clksel(clksel), .mode(mode), .preload(preload),
    .match0(match[0]), .tick_in(tick_in), .snap_req(snap_req), .count(count),
    .cnt_step(cnt_step), .reload(reload), .snap_value(snap_value)
  );

  mtmr_compare #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_cmp (
    .clk(clk), .rst(rst), .count(count), .cnt_step(cnt_step), .match(match),
    .ack_bits(ack_bits), .match_hit(match_hit), .status(status)
  );

  assign irq = |(status & ien);

endmodule

// File: rtl/mtmr_checker.sv
module mtmr_checker
  import mtmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int N_CMP = 3,
  parameter int N_SRC = 4,
  parameter int SEL_W = 2
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        run,
  input logic [SEL_W-1:0]            clksel,
  input cnt_mode_e                   mode,
  input logic [CNT_W-1:0]            preload,
  input logic [N_CMP-1:0][CNT_W-1:0] match,
  input logic [CNT_W-1:0]            count,
  input logic                        cnt_step,
  input logic [N_SRC-1:0]            tick_in,
  input logic [N_CMP-1:0]            ack_bits,
  input logic [N_CMP-1:0]            status,
  input logic [N_CMP-1:0]            ien,
  input logic                        irq
);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(count));

  assert_select_R3: assert property (@(posedge clk) disable iff (rst)
    !tick_in[clksel] |=> $stable(count));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_step && mode == MODE_FREE) |=> count == $past(count) + CNT_W'(1));

  assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt_step && mode == MODE_PERIODIC && count == match[0]) |=> count == $past(preload));

  for (genvar g = 0; g < N_CMP; g++) begin : g_chk
    assert_set_R7: assert property (@(posedge clk) disable iff (rst)
      (cnt_step && count == match[g]) |=> status[g]);   // also covers R9

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      (status[g] && !ack_bits[g]) |=> status[g]);

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
      (ack_bits[g] && !(cnt_step && count == match[g])) |=> !status[g]);
  end

  assert_mask_R10: assert property (@(posedge clk) disable iff (rst)
    (ien == '0) |-> !irq);

  assert_source_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> (status != '0));

endmodule

bind match_timer mtmr_checker #(
  .CNT_W(CNT_W), .N_CMP(N_CMP), .N_SRC(N_SRC), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst(rst), .run(run), .clksel(clksel), .mode(mode), .preload(preload),
  .match(match), .count(count), .cnt_step(cnt_step), .tick_in(tick_in),
  .ack_bits(ack_bits), .status(status), .ien(ien), .irq(irq)
);

// File: tb/match_timer_test.sv
`timescale 1ns/1ps
module match_timer_test;

  localparam int SNAP_DELAY = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  tick_in;
  logic        irq;

  logic [3:0]  tick_val = 4'h0;
  logic        tick_rand = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  match_timer #(.SNAP_DELAY(SNAP_DELAY)) uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_in(tick_in), .irq(irq)
  );

  always @(negedge clk) tick_in <= tick_rand ? 4'($urandom) : tick_val;

  // ---------------- bench reference model ----------------
  logic        m_run;
  logic [1:0]  m_sel;
  logic        m_free;
  logic [31:0] m_pre, m_count, m_snap, m_rdexp;
  logic [31:0] m_match [3];
  logic [2:0]  m_stat, m_ien;

  function automatic logic [31:0] model_read(input logic [3:0] a);
    case (a)
      4'd0: return {31'd0, m_run};
      4'd1: return {30'd0, m_sel};
      4'd2: return {31'd0, m_free};
      4'd3: return m_pre;
      4'd4: return m_snap;
      4'd5: return {29'd0, m_stat};
      4'd7: return {29'd0, m_ien};
      4'd8: return m_match[0];
      4'd9: return m_match[1];
      4'd10: return m_match[2];
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic model_irq();
    for (int i = 0; i < 3; i++) if (m_stat[i] && m_ien[i]) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    logic step, wr;
    logic [2:0] st;
    if (rst) begin
      m_run <= 0; m_sel <= 0; m_free <= 0; m_pre <= 0; m_count <= 0; m_snap <= 0;
      m_rdexp <= 0; m_stat <= 0; m_ien <= 0;
      for (int i = 0; i < 3; i++) m_match[i] <= 0;
    end else begin
      step = m_run && tick_in[m_sel];
      wr = bus_sel && bus_wr;
      st = m_stat;
      for (int i = 0; i < 3; i++) begin
        if (wr && bus_addr == 4'd6 && bus_wdata[i]) st[i] = 1'b0;
        if (step && m_count == m_match[i]) st[i] = 1'b1;
      end
      m_stat <= st;
      if (step) begin
        if (!m_free && m_count == m_match[0]) m_count <= m_pre;
        else m_count <= m_count + 32'd1;
      end
      if (bus_sel && !bus_wr) m_rdexp <= model_read(bus_addr);
      if (wr) begin
        case (bus_addr)
          4'd0: m_run <= bus_wdata[0];
          4'd1: m_sel <= bus_wdata[1:0];
          4'd2: m_free <= bus_wdata[0];
          4'd3: m_pre <= bus_wdata;
          4'd4: if (bus_wdata[0]) m_snap <= m_count;
          4'd7: m_ien <= bus_wdata[2:0];
          4'd8: m_match[0] <= bus_wdata;
          4'd9: m_match[1] <= bus_wdata;
          4'd10: m_match[2] <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_write(input int a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    drive_write(a, d);
  endtask

  task automatic bus_check(input int a, input string req);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 4'(a);
    @(negedge clk);
    bus_sel = 0;
    check32(req, bus_rdata, m_rdexp);
  endtask

  task automatic snap_check(input string req);
    bus_write(4, 32'd1);
    repeat (SNAP_DELAY + 1) @(negedge clk);
    bus_check(4, req);
  endtask

  task automatic irq_check(input string req);
    check32(req, {31'd0, irq}, {31'd0, model_irq()});
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a <= 10; a++) bus_check(a, "R1");
    check32("R1", {31'd0, irq}, 32'd0);
    // R11 unmapped reads
    for (int a = 11; a <= 15; a++) bus_check(a, "R11");

    // R2 run/hold
    tick_val = 4'hF;
    bus_write(2, 32'd1);
    repeat (10) @(negedge clk);
    snap_check("R2");
    check32("R2", bus_rdata, 32'd0);
    bus_write(0, 32'd1);
    repeat (37) @(negedge clk);
    snap_check("R2");
    bus_write(0, 32'd0);
    repeat (9) @(negedge clk);
    snap_check("R2");
    repeat (20) @(negedge clk);
    snap_check("R2");

    // R3 clock select
    bus_write(0, 32'd1);
    bus_write(1, 32'd2);
    tick_val = 4'b1011;
    repeat (20) @(negedge clk);
    snap_check("R3");
    tick_val = 4'b0100;
    repeat (13) @(negedge clk);
    snap_check("R3");
    bus_write(1, 32'd3);
    tick_val = 4'hF;
    repeat (7) @(negedge clk);
    snap_check("R3");

    // R6 snapshot writes without bit 0 do nothing
    bus_write(4, 32'd0);
    repeat (5) @(negedge clk);
    bus_check(4, "R6");
    bus_write(4, 32'd2);
    repeat (5) @(negedge clk);
    bus_check(4, "R6");

    // R5 periodic reload from 0
    bus_write(2, 32'd0);
    bus_write(3, 32'd0);
    bus_write(8, m_count + 32'd30);
    repeat (60) @(negedge clk);
    snap_check("R5");
    bus_check(3, "R5");

    // R5 reload to near the top, then R4 wrap in free mode
    bus_write(3, 32'hFFFF_FFF0);
    bus_write(8, m_count + 32'd20);
    while (m_count != 32'hFFFF_FFF0) @(negedge clk);
    check32("R5", m_count, 32'hFFFF_FFF0);
    snap_check("R5");
    bus_write(2, 32'd1);
    repeat (40) @(negedge clk);
    snap_check("R4");
    repeat (150) @(negedge clk);
    snap_check("R4");

    // R7 / R10 / R8
    bus_write(6, 32'h7);
    bus_write(7, 32'h0);
    bus_write(9, m_count + 32'd40);
    bus_write(10, m_count + 32'd60);
    repeat (70) @(negedge clk);
    bus_check(5, "R7");
    irq_check("R10");
    bus_write(7, 32'h2);
    irq_check("R10");
    snap_check("R10");
    bus_check(5, "R10");
    bus_write(6, 32'h2);
    bus_check(5, "R8");
    irq_check("R8");
    bus_write(6, 32'h0);
    bus_check(5, "R8");
    bus_write(6, 32'h7);
    bus_check(5, "R8");
    bus_check(6, "R8");

    // R9 set and acknowledge collide
    begin
      logic [31:0] tgt;
      tgt = m_count + 32'd30;
      bus_write(9, tgt);
      bus_write(6, 32'h7);
      @(negedge clk);
      while (m_count != tgt) @(negedge clk);
      drive_write(6, 32'h2);
      bus_check(5, "R9");
      check32("R9", {31'd0, bus_rdata[1]}, 32'd1);
      irq_check("R9");
    end

    // Random phase
    tick_rand = 1'b1;
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 6);
      case (op)
        0: bus_write(8 + int'($urandom % 3), m_count + 32'd16 + ($urandom % 120));
        1: bus_write(6, $urandom % 8);
        2: bus_write(7, $urandom % 8);
        3: bus_check(5, "R7");
        4: repeat (int'($urandom % 8)) @(negedge clk);
        default: snap_check("R6");
      endcase
      irq_check("R10");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule